// File: doc/BRIEF.md
# Rotating-Priority Bus Arbiter with Parking

This block decides which of several masters may drive a shared parallel bus. There are eight request inputs. Index 0 belongs to the bridge, and indices 1 to 7 serve up to seven peripheral masters. Request and grant lines are active-low. The arbiter watches the bus FRAME and IRDY status lines (both active-low) to tell whether the granted master has started a transaction and when the bus is idle again.

Ownership moves in a rotating order so that no requester is starved. The search for the next owner starts at the index just after the current owner and wraps around. When nobody else is asking, the grant stays parked on the last owner. After reset it is parked on the bridge. A master that holds a grant while others wait, and that never starts a transaction, loses the grant after a fixed window of clocks. A master that has started a transaction keeps its grant until the bus is idle again. Every change of owner passes through one clock in which no grant is driven, so two masters never see a grant in neighbouring cycles.

Top module: `arb_rr_park`

## Requirements
- R1: While rst_n is low at a clock edge (synchronous, active-low), the block is reset. In the first cycle after reset the grant is parked on the bridge: gnt_n equals 8'b1111_1110.
- R2: In every cycle at most one bit of gnt_n is low. Bit i low means master i holds the grant.
- R3: Whenever the owner changes, exactly one cycle with gnt_n all ones lies between the old grant and the new one. An all-ones cycle always lasts exactly one clock.
- R4: Suppose the owner's request is high (inactive), frame_n and irdy_n are both high, and some other req_n bit is low at a clock edge. Then gnt_n is all ones in the next cycle and the new grant appears in the cycle after that.
- R5: The new owner is the first master with req_n low in the order owner+1, owner+2, … taken modulo 8. The current owner's own request is not part of this search.
- R6: Suppose the owner still requests, another request is pending and frame_n stays high. Then the grant is held for at most 16 consecutive cycles and is then withdrawn.
- R7: While no master other than the owner has req_n low, the grant stays on the owner indefinitely, whatever the owner's own request. No timeout applies.
- R8: Once frame_n has been sampled low during a grant, that grant is held until an edge at which frame_n and irdy_n are both high.
- R9: A master that lost its grant by timeout keeps no advantage. It is searched last, after every other pending requester.
- R10: When the bus returns to idle after a transaction and another request is pending, the grant is released in the next cycle, even if the owner still requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active-low |
| req_n | input | NREQ (8) | Request lines, active-low; index 0 is the bridge |
| frame_n | input | 1 | Bus FRAME status, active-low |
| irdy_n | input | 1 | Bus IRDY status, active-low |
| gnt_n | output | NREQ (8) | Grant lines, active-low, at most one low |

## Verification
A wrong owner register shows up at once as a grant on the wrong index in the cycle after the gap. A stuck or miscounting wait timer shows up as a grant that is withdrawn before or after the sixteenth waiting cycle, or never withdrawn. A transaction-phase state that is lost early shows up as a grant that moves while frame_n or irdy_n is still low. A missing gap state shows up as two different grants in neighbouring cycles. The bench compares gnt_n every cycle against a behavioural model under random request and transaction traffic. Directed sequences pin the exact cycle of the timeout, of a hand-over and of the release after a transaction.

// File: rtl/arb_pkg.sv
// Shared types of the rotating-priority bus arbiter.
// Assumes: used by every module of the arbiter, compiled first.
package arb_pkg;

    // Phase of the current grant:
    //   OWN  - grant driven, no transaction seen yet (or parked after one)
    //   XFER - granted master has started a transaction, wait for idle
    //   GAP  - all grants off for one clock before the new owner
    typedef enum logic [1:0] {
        ARB_OWN  = 2'd0,
        ARB_XFER = 2'd1,
        ARB_GAP  = 2'd2
    } arb_phase_e;

endpackage

// File: rtl/arb_rot_pick.sv
// Rotating-priority search: returns the first active request after
// index 'last' in circular order, never 'last' itself.
// Assumes: req is active-high here; NREQ >= 2. A power-of-two NREQ
// wraps by truncation, any other count wraps by subtraction.
module arb_rot_pick #(
    parameter int NREQ = 8,
    localparam int IW = $clog2(NREQ)
) (
    input  logic [NREQ-1:0] req,
    input  logic [IW-1:0]   last,
    output logic [IW-1:0]   win,
    output logic            hit
);

    localparam bit POW2 = (NREQ == (1 << IW));

    generate
        if (POW2) begin : g_wrap_trunc
            logic [IW-1:0] idx;
            // Scan from farthest to nearest so the nearest hit wins.
            always_comb begin
                win = last;
                hit = 1'b0;
                idx = last;
                for (int k = NREQ - 1; k >= 1; k--) begin
                    idx = last + IW'(k);
                    if (req[idx]) begin
                        win = idx;
                        hit = 1'b1;
                    end
                end
            end
        end else begin : g_wrap_sub
            logic [IW:0] sum;
            // Same scan, index folded back into range by subtraction.
            always_comb begin
                win = last;
                hit = 1'b0;
                sum = '0;
                for (int k = NREQ - 1; k >= 1; k--) begin
                    sum = {1'b0, last} + (IW+1)'(k);
                    if (sum >= (IW+1)'(NREQ)) begin
                        sum = sum - (IW+1)'(NREQ);
                    end
                    if (req[sum[IW-1:0]]) begin
                        win = sum[IW-1:0];
                        hit = 1'b1;
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/arb_wait_timer.sv
// Counts consecutive clocks in which the owner waits without a
// transaction while others are pending; flags the last allowed clock.
// Assumes: LIMIT >= 2; 'run' low clears the count.
module arb_wait_timer #(
    parameter int LIMIT = 16,
    localparam int CW = $clog2(LIMIT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Advance while waiting, saturate at the last clock, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    // This clock is the last of the window.
    assign expired = run && (cnt == LAST);

endmodule

// File: rtl/arb_grant_dec.sv
// Turns owner index plus an enable into active-low one-hot grant lines.
// Assumes: owner < NREQ whenever 'on' is high.
module arb_grant_dec #(
    parameter int NREQ = 8,
    localparam int IW = $clog2(NREQ)
) (
    input  logic            on,
    input  logic [IW-1:0]   owner,
    output logic [NREQ-1:0] gnt_n
);

    generate
        for (genvar i = 0; i < NREQ; i++) begin : g_line
            // One line per master, low only for the enabled owner.
            assign gnt_n[i] = ~(on && (owner == IW'(i)));
        end
    endgenerate

endmodule

// File: rtl/arb_ctrl.sv
// Grant phase machine and owner register of the arbiter.
// Assumes: win/hit come from a rotating search that excludes the current
// owner, and expired from a wait timer driven by timer_run.
module arb_ctrl
    import arb_pkg::*;
#(
    parameter int NREQ = 8,
    localparam int IW = $clog2(NREQ)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] req_n,
    input  logic            frame_n,
    input  logic            irdy_n,
    input  logic [IW-1:0]   win,
    input  logic            hit,
    input  logic            expired,
    output logic [IW-1:0]   owner,
    output logic            gnt_on,
    output logic            timer_run
);

    arb_phase_e    phase, phase_nx;
    logic [IW-1:0] owner_nx;
    logic          used, used_nx;
    logic          owner_req;
    logic          bus_idle;

    assign owner_req = ~req_n[owner];
    assign bus_idle  = frame_n && irdy_n;
    assign gnt_on    = (phase != ARB_GAP);

    // Wait window runs only for a fresh grant that others are waiting on.
    always_comb begin
        timer_run = (phase == ARB_OWN) && !used && hit && frame_n;
    end

    // Next phase, next owner and the "transaction done" flag.
    always_comb begin
        phase_nx = phase;
        owner_nx = owner;
        used_nx  = used;
        unique case (phase)
            ARB_OWN: begin
                if (!frame_n) begin
                    phase_nx = ARB_XFER;
                end else if (hit && (!owner_req || used || expired)) begin
                    phase_nx = ARB_GAP;
                    owner_nx = win;
                end
            end
            ARB_XFER: begin
                if (bus_idle) begin
                    if (hit) begin
                        phase_nx = ARB_GAP;
                        owner_nx = win;
                    end else begin
                        phase_nx = ARB_OWN;
                        used_nx  = 1'b1;
                    end
                end
            end
            ARB_GAP: begin
                phase_nx = ARB_OWN;
                used_nx  = 1'b0;
            end
            default: begin
                phase_nx = ARB_GAP;
            end
        endcase
    end

    // State registers; reset parks the bus on the bridge (index 0).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= ARB_OWN;
            owner <= '0;
            used  <= 1'b0;
        end else begin
            phase <= phase_nx;
            owner <= owner_nx;
            used  <= used_nx;
        end
    end

endmodule

// File: rtl/arb_rr_park.sv
// Top of the rotating-priority bus arbiter with parking and a
// no-start timeout. Index 0 is the bridge and the reset owner.
// Assumes: synchronous active-low reset; all request and grant lines
// are active-low; frame_n/irdy_n are the shared bus status lines.
module arb_rr_park #(
    parameter int NREQ    = 8,
    parameter int TIMEOUT = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] req_n,
    input  logic            frame_n,
    input  logic            irdy_n,
    output logic [NREQ-1:0] gnt_n
);

    localparam int IW = $clog2(NREQ);

    logic [IW-1:0] owner;
    logic [IW-1:0] win;
    logic          hit;
    logic          expired;
    logic          timer_run;
    logic          gnt_on;

    arb_rot_pick #(.NREQ(NREQ)) u_pick (
        .req  (~req_n),
        .last (owner),
        .win  (win),
        .hit  (hit)
    );

    arb_wait_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timer_run),
        .expired (expired)
    );

    arb_ctrl #(.NREQ(NREQ)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_n     (req_n),
        .frame_n   (frame_n),
        .irdy_n    (irdy_n),
        .win       (win),
        .hit       (hit),
        .expired   (expired),
        .owner     (owner),
        .gnt_on    (gnt_on),
        .timer_run (timer_run)
    );

    arb_grant_dec #(.NREQ(NREQ)) u_dec (
        .on    (gnt_on),
        .owner (owner),
        .gnt_n (gnt_n)
    );

endmodule

// File: rtl/arb_rr_park_chk.sv
// Port-level property checker for arb_rr_park, bound to every instance.
// Assumes: the same NREQ/TIMEOUT as the checked instance.
module arb_rr_park_chk #(
    parameter int NREQ    = 8,
    parameter int TIMEOUT = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NREQ-1:0] req_n,
    input logic            frame_n,
    input logic            irdy_n,
    input logic [NREQ-1:0] gnt_n
);

    localparam logic [NREQ-1:0] NONE = '1;
    localparam logic [NREQ-1:0] BRIDGE = ~NREQ'(1);
    localparam int WW = $clog2(TIMEOUT + 1) + 1;

    logic          granted, others, own_req, idle, in_tx, wait_cond;
    logic [WW-1:0] wait_cnt;

    assign granted   = (gnt_n != NONE);
    assign others    = granted && (((~req_n) & gnt_n) != '0);
    assign own_req   = ((~req_n) & (~gnt_n)) != '0;
    assign idle      = frame_n && irdy_n;
    assign wait_cond = granted && frame_n && !in_tx && others;

    // Track a transaction begun under the current grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_tx <= 1'b0;
        end else begin
            in_tx <= granted && (!frame_n || (in_tx && !idle));
        end
    end

    // Count consecutive clocks of waiting without a transaction.
    always_ff @(posedge clk) begin
        if (!rst_n || !wait_cond) begin
            wait_cnt <= '0;
        end else if (wait_cnt != '1) begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    a_r1_reset_park: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> gnt_n == BRIDGE);

    a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~gnt_n) <= 1);

    a_r3_gap_on_move: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(gnt_n) != NONE && granted) |-> gnt_n == $past(gnt_n));

    a_r3_gap_one_clk: assert property (@(posedge clk) disable iff (!rst_n)
        !granted |=> granted);

    a_r4_fast_release: assert property (@(posedge clk) disable iff (!rst_n)
        (granted && idle && !own_req && others) |=> !granted);

    a_r6_timeout_bound: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cond |-> wait_cnt < WW'(TIMEOUT));

    a_r7_park_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (granted && !others) |=> gnt_n == $past(gnt_n));

    a_r8_hold_in_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (granted && (!frame_n || (in_tx && !idle))) |=> gnt_n == $past(gnt_n));

    a_r10_release_after_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (granted && in_tx && idle && others) |=> !granted);

endmodule

bind arb_rr_park arb_rr_park_chk #(.NREQ(NREQ), .TIMEOUT(TIMEOUT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_n   (req_n),
    .frame_n (frame_n),
    .irdy_n  (irdy_n),
    .gnt_n   (gnt_n)
);

// File: tb/sim_arb_rr_park.sv
// Bench: directed hand-over, timeout and transaction sequences, then
// seeded random traffic compared cycle by cycle with a behavioural model.
module sim_arb_rr_park;

    localparam int CLK_PERIOD  = 10;
    localparam int NREQ        = 8;
    localparam int TIMEOUT     = 16;
    localparam int RAND_CYCLES = 4000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NREQ-1:0] req_n = '1;
    logic            frame_n = 1'b1;
    logic            irdy_n = 1'b1;
    logic [NREQ-1:0] gnt_n;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    arb_rr_park #(.NREQ(NREQ), .TIMEOUT(TIMEOUT)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_n   (req_n),
        .frame_n (frame_n),
        .irdy_n  (irdy_n),
        .gnt_n   (gnt_n)
    );

    // Grant word expected for owner i.
    function automatic logic [NREQ-1:0] gw(int i);
        logic [NREQ-1:0] w;
        w = '1;
        w[i] = 1'b0;
        return w;
    endfunction

    // First requester after 'last' in circular order, or -1.
    function automatic int next_after(int last, logic [NREQ-1:0] rq_n);
        for (int k = 1; k < NREQ; k++) begin
            if (!rq_n[(last + k) % NREQ]) return (last + k) % NREQ;
        end
        return -1;
    endfunction

    // Behavioural model: 0 granted, 1 in transaction, 2 gap.
    int m_owner, m_phase, m_wait;
    bit m_used;

    always @(posedge clk) begin
        int nx;
        nx = next_after(m_owner, req_n);
        if (!rst_n) begin
            m_owner <= 0; m_phase <= 0; m_used <= 1'b0; m_wait <= 0;
        end else if (m_phase == 0) begin
            if (!frame_n) begin
                m_phase <= 1;
            end else if (nx >= 0 && (req_n[m_owner] || m_used || m_wait == TIMEOUT - 1)) begin
                m_phase <= 2;
                m_owner <= nx;
            end
            m_wait <= (frame_n && !m_used && nx >= 0) ? m_wait + 1 : 0;
        end else if (m_phase == 1) begin
            m_wait <= 0;
            if (frame_n && irdy_n) begin
                if (nx >= 0) begin
                    m_phase <= 2;
                    m_owner <= nx;
                end else begin
                    m_phase <= 0;
                    m_used  <= 1'b1;
                end
            end
        end else begin
            m_wait  <= 0;
            m_phase <= 0;
            m_used  <= 1'b0;
        end
    end

    function automatic logic [NREQ-1:0] model_gnt();
        return (m_phase == 2) ? '1 : gw(m_owner);
    endfunction

    task automatic check(input string tag, input logic [NREQ-1:0] exp);
        n_vec++;
        if (gnt_n !== exp) begin
            n_bad++;
            $display("FAIL %s: gnt_n=%b expected %b at %0t", tag, gnt_n, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Watchdog: a hung run ends as a failure with the summary line.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run still going, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int tx_left;
        logic [NREQ-1:0] lazy;
        void'($urandom(32'h5EED_0042));
        tx_left = 0;
        lazy = '0;

        // R1: reset parks on the bridge.
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset park", 8'hFE);
        // R7: bridge parked with nobody requesting, no timeout.
        for (int k = 0; k < 20; k++) begin tick(); check("R7 park bridge", 8'hFE); end

        // R4: single request from 3, owner idle: gap then grant.
        req_n[3] = 1'b0;
        tick(); check("R4 gap", 8'hFF);
        tick(); check("R4 grant 3", 8'hF7);

        // R7: parked on 3 with and without its own request.
        req_n = '1;
        for (int k = 0; k < 20; k++) begin tick(); check("R7 park 3", 8'hF7); end
        req_n[3] = 1'b0;
        for (int k = 0; k < 25; k++) begin tick(); check("R7 no timeout alone", 8'hF7); end

        // R5: from owner 3, requests 1 and 6 -> 6 first.
        req_n = '1; req_n[1] = 1'b0; req_n[6] = 1'b0;
        tick(); check("R3 gap", 8'hFF);
        tick(); check("R5 rotate to 6", 8'hBF);
        req_n[6] = 1'b1;
        tick(); check("R3 gap", 8'hFF);
        tick(); check("R5 wrap to 1", 8'hFD);
        // From owner 1, requests 0 and 7 -> 7 precedes 0.
        req_n = '1; req_n[0] = 1'b0; req_n[7] = 1'b0;
        tick(); check("R3 gap", 8'hFF);
        tick(); check("R5 rotate to 7", 8'h7F);

        // R6: 7 keeps requesting, never starts; 0 pending.
        for (int k = 0; k <= 16; k++) begin
            tick();
            if (k < 15) check("R6 hold window", 8'h7F);
            else if (k == 15) check("R6 withdrawn", 8'hFF);
            else check("R6 next owner 0", 8'hFE);
        end

        // R8: owner 0 starts a transaction; 7 pending.
        frame_n = 1'b0; irdy_n = 1'b0;
        for (int k = 0; k < 5; k++) begin tick(); check("R8 hold in tx", 8'hFE); end
        frame_n = 1'b1;
        tick(); check("R8 hold last data", 8'hFE);
        irdy_n = 1'b1;
        tick(); check("R10 release after tx", 8'hFF);
        tick(); check("R10 grant 7", 8'h7F);
        req_n[0] = 1'b1;
        for (int k = 0; k < 5; k++) begin tick(); check("R7 park 7", 8'h7F); end

        // R9: 7 times out with 2 and 5 pending; it then waits its turn.
        req_n[2] = 1'b0; req_n[5] = 1'b0;
        for (int k = 0; k <= 16; k++) begin
            tick();
            if (k < 15) check("R6 hold window", 8'h7F);
            else if (k == 15) check("R6 withdrawn", 8'hFF);
            else check("R9 next after 7 is 2", 8'hFB);
        end
        req_n[2] = 1'b1;
        tick(); check("R3 gap", 8'hFF);
        tick(); check("R9 5 before timed-out 7", 8'hDF);
        req_n[5] = 1'b1;
        tick(); check("R3 gap", 8'hFF);
        tick(); check("R9 7 served last", 8'h7F);
        req_n = '1;
        tick(); check("R7 park 7", 8'h7F);

        // Random traffic against the model (R2, R5, R6, R8, R10).
        for (int c = 0; c < RAND_CYCLES; c++) begin
            if (c % 500 == 0) lazy = NREQ'($urandom());
            for (int i = 0; i < NREQ; i++) begin
                if ($urandom_range(0, 9) == 0) req_n[i] = ~req_n[i];
            end
            if (tx_left > 1) begin
                frame_n = 1'b0; irdy_n = 1'b0; tx_left--;
            end else if (tx_left == 1) begin
                frame_n = 1'b1; irdy_n = 1'b0; tx_left = 0;
            end else begin
                frame_n = 1'b1; irdy_n = 1'b1;
                for (int i = 0; i < NREQ; i++) begin
                    if (!gnt_n[i] && !req_n[i] && !lazy[i] && $urandom_range(0, 2) == 0) begin
                        frame_n = 1'b0; irdy_n = 1'b0;
                        tx_left = $urandom_range(2, 6);
                    end
                end
            end
            tick();
            check("R5 random vs model", model_gnt());
            n_vec++;
            if ($countones(~gnt_n) > 1) begin
                n_bad++;
                $display("FAIL R2 one grant: gnt_n=%b expected at most one low", gnt_n);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule